// File: doc/BRIEF.md
# Prioritised Restart Interrupt Arbiter

This block collects five interrupt requests for an 8-bit processor core and decides which one the core should take next. One request is non-maskable and always wins. Three are restart requests that carry a built-in vector address. The last is a general request that sits at the bottom of the order and has no vector of its own. The core owns a global enable, a three-bit restart mask, and a clear command for the edge-held restart request. The core supplies a strobe at each instruction boundary. At that boundary the arbiter evaluates the qualified requests and, when there is a winner, raises a pending flag with the winner's source code and vector. That selection stays frozen until the core acknowledges it.

The control is a two-state machine. IDLE waits for a boundary. PEND holds a captured selection. The transition RAISE (IDLE to PEND) fires when the boundary strobe is high and at least one qualified request exists. The transition RETIRE (PEND to IDLE) fires on the acknowledge strobe. An acknowledge in IDLE does nothing, and so does a boundary in PEND.

Top module: `restart_irq_ctrl`

## Requirements
- R1: Priority from highest to lowest is non-maskable, high restart, middle restart, low restart, general request. Source codes are 5, 4, 3, 2, 1 in that order, and 0 means none.
- R2: The non-maskable request ignores the global enable and the masks. It is accepted only when a rising edge on `nmi_in` has been captured and `nmi_in` is still high at the boundary.
- R3: A rising edge on `rs_hi_in` is held, even while masked, until it is acknowledged or cleared by a mask write with `mask_clr_hi` = 1.
- R4: The middle restart, low restart and general requests are level-sensitive. They count only if they are high at the boundary.
- R5: The vectors are 0x0024 for source 5, 0x002C for source 2, 0x0034 for source 3 and 0x003C for source 4. `irq_vec_valid` is 0 with vector 0x0000 for source 1.
- R6: A mask write loads `mask_data` (bit 2 high, bit 1 middle, bit 0 low restart, 1 = masked). Reset sets all three masks. The restart and general requests also need the global enable.
- R7: Reset and `ien_clr` clear the global enable, and `ien_set` sets it. Acknowledging a pending request clears it, and this wins over an `ien_set` in the same cycle.
- R8: `irq_pending` rises only in the cycle after a boundary strobe. Source and vector then stay fixed until an acknowledge, which drops the flag on the next cycle.
- R9: If a new rising edge on `rs_hi_in` arrives in the same cycle as the acknowledge of source 4, the held request stays set.
- R10: Acknowledging source 5 clears the captured non-maskable edge, so a line that stays high is not taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request line |
| rs_hi_in | input | 1 | High restart request (edge) |
| rs_mid_in | input | 1 | Middle restart request (level) |
| rs_lo_in | input | 1 | Low restart request (level) |
| irq_in | input | 1 | General request (level) |
| ien_set | input | 1 | Set global enable |
| ien_clr | input | 1 | Clear global enable |
| mask_wr | input | 1 | Mask write command |
| mask_data | input | 3 | Restart masks written by the command |
| mask_clr_hi | input | 1 | With mask_wr, discards the held high restart request |
| boundary | input | 1 | Instruction boundary strobe |
| ack | input | 1 | Acknowledge of the pending request |
| irq_pending | output | 1 | A selection is waiting |
| irq_src | output | 3 | Selected source code |
| irq_vec | output | 16 | Restart vector address |
| irq_vec_valid | output | 1 | Vector applies to the selected source |

## Verification
Two collisions matter here. In the first, an acknowledge of the held high restart request arrives in the same cycle as a fresh rising edge on that input. The bench drives both in one cycle, then re-enables and strobes a boundary, and expects source 4 again. In the second, an acknowledge coincides with an enable-set command. That is judged by strobing a boundary with the general request high and expecting nothing pending.

// File: rtl/rsti_pkg.sv
package rsti_pkg;
    localparam int NUM_SRC  = 5;
    localparam int NUM_RST  = 3;
    localparam int VEC_W    = 16;
    localparam int SRC_W    = 3;
    localparam logic [VEC_W-1:0] VEC_NMI  = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0024;
    localparam int VEC_STEP = 8;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_IRQ  = 3'd1,
        SRC_RLO  = 3'd2,
        SRC_RMID = 3'd3,
        SRC_RHI  = 3'd4,
        SRC_NMI  = 3'd5
    } src_e;

    function automatic logic [VEC_W-1:0] vec_of(input src_e s);
        logic [VEC_W-1:0] v;
        unique case (s)
            SRC_NMI:                    v = VEC_NMI;
            SRC_RLO, SRC_RMID, SRC_RHI: v = VEC_BASE + VEC_W'(VEC_STEP * (int'(s) - 1));
            default:                    v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/rsti_edge_latch.sv
module rsti_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic clr,
    output logic held
);
    logic prev_q;
    logic rise;

    assign rise = din & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            held   <= 1'b0;
        end else begin
            prev_q <= din;
            held   <= (held & ~clr) | rise;
        end
    end

    // R3: a held edge survives any cycle without a clear
    p_hold_until_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        held && !clr |=> held);
    // R9: a fresh edge wins over a simultaneous clear
    p_edge_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise && clr |=> held);
endmodule

// File: rtl/rsti_prio_sel.sv
module rsti_prio_sel
    import rsti_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output src_e               sel
);
    always_comb begin
        sel = SRC_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) sel = src_e'(SRC_W'(i + 1));
        end
    end
endmodule

// File: rtl/rsti_ctl.sv
module rsti_ctl
    import rsti_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary,
    input  logic               ack,
    input  logic               ien_set,
    input  logic               ien_clr,
    input  logic               mask_wr,
    input  logic [NUM_RST-1:0] mask_data,
    input  logic               mask_clr_hi,
    input  logic               nmi_held,
    input  logic               nmi_lvl,
    input  logic               hi_held,
    input  logic               mid_lvl,
    input  logic               lo_lvl,
    input  logic               irq_lvl,
    input  src_e               sel,
    output logic [NUM_SRC-1:0] req,
    output logic               clr_nmi,
    output logic               clr_hi,
    output logic               pending,
    output src_e               src_q,
    output logic [VEC_W-1:0]   vec_q,
    output logic               vec_valid
);
    typedef enum logic {ST_IDLE, ST_PEND} state_e;

    state_e             state_q, state_d;
    logic               ien_q;
    logic [NUM_RST-1:0] mask_q;
    logic [NUM_RST-1:0] rst_lvl;
    logic               take, retire;

    assign rst_lvl = {hi_held, mid_lvl, lo_lvl};

    generate
        for (genvar k = 0; k < NUM_RST; k++) begin : g_rst_qual
            assign req[k+1] = rst_lvl[k] & ~mask_q[k] & ien_q;
        end
    endgenerate
    assign req[0]         = irq_lvl & ien_q;
    assign req[NUM_SRC-1] = nmi_held & nmi_lvl;

    assign take   = (state_q == ST_IDLE) && boundary && (|req);
    assign retire = (state_q == ST_PEND) && ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take)   state_d = ST_PEND;
            ST_PEND: if (retire) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_NONE;
            vec_q <= '0;
        end else if (take) begin
            src_q <= sel;
            vec_q <= vec_of(sel);
        end else if (retire) begin
            src_q <= SRC_NONE;
            vec_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            mask_q <= '1;
        end else begin
            if (retire)       ien_q <= 1'b0;
            else if (ien_set) ien_q <= 1'b1;
            else if (ien_clr) ien_q <= 1'b0;
            if (mask_wr) mask_q <= mask_data;
        end
    end

    assign pending   = (state_q == ST_PEND);
    assign vec_valid = pending && (src_q != SRC_IRQ);
    assign clr_nmi   = retire && (src_q == SRC_NMI);
    assign clr_hi    = (retire && (src_q == SRC_RHI)) || (mask_wr && mask_clr_hi);

    // R8: the flag can only rise after a boundary strobe
    p_rise_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(boundary));
    // R8: the selection stays frozen while unacknowledged
    p_src_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !ack |=> pending && $stable(src_q) && $stable(vec_q));
    // R7: acknowledge leaves the enable cleared
    p_ack_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !ien_q);
    // R1: a qualified non-maskable request always wins
    p_nmi_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && boundary && req[NUM_SRC-1] |=> src_q == SRC_NMI);
    // R5: vectors are restricted to the four restart addresses
    p_vec_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_q == 16'h0024 || vec_q == 16'h002C ||
                       vec_q == 16'h0034 || vec_q == 16'h003C));
endmodule

// File: rtl/restart_irq_ctrl.sv
module restart_irq_ctrl
    import rsti_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_in,
    input  logic             rs_hi_in,
    input  logic             rs_mid_in,
    input  logic             rs_lo_in,
    input  logic             irq_in,
    input  logic             ien_set,
    input  logic             ien_clr,
    input  logic             mask_wr,
    input  logic [2:0]       mask_data,
    input  logic             mask_clr_hi,
    input  logic             boundary,
    input  logic             ack,
    output logic             irq_pending,
    output logic [2:0]       irq_src,
    output logic [VEC_W-1:0] irq_vec,
    output logic             irq_vec_valid
);
    logic [NUM_SRC-1:0] req;
    logic               nmi_held, hi_held, clr_nmi, clr_hi;
    src_e               sel, src_q;

    rsti_edge_latch u_nmi_latch (
        .clk(clk), .rst_n(rst_n), .din(nmi_in), .clr(clr_nmi), .held(nmi_held)
    );

    rsti_edge_latch u_hi_latch (
        .clk(clk), .rst_n(rst_n), .din(rs_hi_in), .clr(clr_hi), .held(hi_held)
    );

    rsti_prio_sel u_sel (
        .req(req), .sel(sel)
    );

    rsti_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .ack(ack),
        .ien_set(ien_set), .ien_clr(ien_clr), .mask_wr(mask_wr),
        .mask_data(mask_data), .mask_clr_hi(mask_clr_hi),
        .nmi_held(nmi_held), .nmi_lvl(nmi_in), .hi_held(hi_held),
        .mid_lvl(rs_mid_in), .lo_lvl(rs_lo_in), .irq_lvl(irq_in),
        .sel(sel), .req(req), .clr_nmi(clr_nmi), .clr_hi(clr_hi),
        .pending(irq_pending), .src_q(src_q), .vec_q(irq_vec),
        .vec_valid(irq_vec_valid)
    );

    assign irq_src = src_q;
endmodule

// File: tb/tb_restart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_restart_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n;
    logic nmi_in, rs_hi_in, rs_mid_in, rs_lo_in, irq_in;
    logic ien_set, ien_clr, mask_wr, mask_clr_hi, boundary, ack;
    logic [2:0]  mask_data;
    logic        irq_pending, irq_vec_valid;
    logic [2:0]  irq_src;
    logic [15:0] irq_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    restart_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .rs_hi_in(rs_hi_in),
        .rs_mid_in(rs_mid_in), .rs_lo_in(rs_lo_in), .irq_in(irq_in),
        .ien_set(ien_set), .ien_clr(ien_clr), .mask_wr(mask_wr),
        .mask_data(mask_data), .mask_clr_hi(mask_clr_hi), .boundary(boundary),
        .ack(ack), .irq_pending(irq_pending), .irq_src(irq_src),
        .irq_vec(irq_vec), .irq_vec_valid(irq_vec_valid)
    );

    // {nmi, hi, mid, lo, irq, ien, mask[2:0], expected source}
    localparam logic [11:0] TBL [12] = '{
        12'b0_0_0_0_1_1_000_001,
        12'b0_0_0_0_1_0_000_000,
        12'b0_0_0_1_1_1_000_010,
        12'b0_0_1_1_0_1_000_011,
        12'b0_1_1_1_1_1_000_100,
        12'b1_1_1_1_1_1_000_101,
        12'b1_0_0_0_0_0_111_101,
        12'b0_1_1_1_1_1_111_001,
        12'b0_0_1_1_0_1_010_010,
        12'b0_1_1_0_0_1_100_011,
        12'b0_0_0_1_0_1_001_000,
        12'b0_1_0_0_0_0_000_000
    };

    function automatic logic [15:0] exp_vec(input logic [2:0] s);
        case (s)
            3'd5:    return 16'h0024;
            3'd2:    return 16'h002C;
            3'd3:    return 16'h0034;
            3'd4:    return 16'h003C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_sel(input string tag, input logic [2:0] s);
        check({tag, " pending"}, 16'(irq_pending), 16'(s != 3'd0));
        check({tag, " source"},  16'(irq_src), 16'(s));
        check({tag, " vector"},  irq_vec, exp_vec(s));
        check({tag, " vec_valid"}, 16'(irq_vec_valid), 16'(s >= 3'd2));
    endtask

    task automatic strobe();
        boundary = 1'b1; tick(); boundary = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic en();
        ien_set = 1'b1; tick(); ien_set = 1'b0;
    endtask

    task automatic mwrite(input logic [2:0] m, input logic c);
        mask_wr = 1'b1; mask_data = m; mask_clr_hi = c; tick();
        mask_wr = 1'b0; mask_clr_hi = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        {nmi_in, rs_hi_in, rs_mid_in, rs_lo_in, irq_in} = '0;
        {ien_set, ien_clr, mask_wr, mask_clr_hi, boundary, ack} = '0;
        mask_data = '0;
        do_reset();
        check_sel("reset R8", 3'd0);

        // R6: masks set after reset
        en(); rs_lo_in = 1'b1; rs_mid_in = 1'b1; tick();
        strobe();
        check("R6 reset masks", 16'(irq_pending), 16'd0);
        rs_lo_in = 1'b0; rs_mid_in = 1'b0; tick();

        // Vector table walk: R1 R5 R6
        for (int e = 0; e < 12; e++) begin
            logic [11:0] t;
            t = TBL[e];
            {nmi_in, rs_hi_in, rs_mid_in, rs_lo_in, irq_in} = '0; tick();
            mask_wr = 1'b1; mask_data = t[5:3]; mask_clr_hi = 1'b1;
            ien_set = t[6]; ien_clr = ~t[6]; tick();
            {mask_wr, mask_clr_hi, ien_set, ien_clr} = '0;
            {nmi_in, rs_hi_in, rs_mid_in, rs_lo_in, irq_in} = t[11:7]; tick();
            strobe();
            check_sel($sformatf("R1 R5 R6 entry %0d", e), t[2:0]);
            if (t[2:0] != 3'd0) begin
                do_ack();
                check("R8 ack drops", 16'(irq_pending), 16'd0);
            end
        end
        {nmi_in, rs_hi_in, rs_mid_in, rs_lo_in, irq_in} = '0;
        do_reset();
        check_sel("reset R7", 3'd0);

        // R8: only at a boundary
        mwrite(3'b000, 1'b0); en();
        irq_in = 1'b1; tick(); tick(); tick();
        check("R8 no boundary", 16'(irq_pending), 16'd0);
        strobe();
        check_sel("R8 boundary", 3'd1);
        // R8: frozen against a higher arrival
        nmi_in = 1'b1; tick(); strobe();
        check_sel("R8 frozen", 3'd1);
        do_ack();
        check("R8 ack", 16'(irq_pending), 16'd0);
        // R2: taken with enable cleared
        strobe();
        check_sel("R2 ignores enable", 3'd5);
        do_ack();
        // R10: latch cleared, steady line not retaken
        strobe();
        check("R10 no retake", 16'(irq_pending), 16'd0);
        nmi_in = 1'b0;

        // R7: ack clears enable
        strobe();
        check("R7 disabled after ack", 16'(irq_pending), 16'd0);
        en(); strobe();
        check_sel("R7 re-enabled", 3'd1);
        ack = 1'b1; ien_set = 1'b1; tick(); ack = 1'b0; ien_set = 1'b0;
        strobe();
        check("R7 ack beats set", 16'(irq_pending), 16'd0);
        irq_in = 1'b0; tick();

        // R2: line fallen before boundary
        nmi_in = 1'b1; tick(); nmi_in = 1'b0; tick();
        strobe();
        check("R2 line low", 16'(irq_pending), 16'd0);
        nmi_in = 1'b1; tick(); strobe();
        check_sel("R2 edge and level", 3'd5);
        do_ack(); nmi_in = 1'b0; tick();

        // R4: level gone before boundary
        en(); rs_mid_in = 1'b1; tick(); rs_mid_in = 1'b0; tick();
        strobe();
        check("R4 level gone", 16'(irq_pending), 16'd0);

        // R3: held after the pulse
        rs_hi_in = 1'b1; tick(); rs_hi_in = 1'b0; tick(); tick();
        strobe();
        check_sel("R3 held pulse", 3'd4);
        do_ack(); en(); strobe();
        check("R3 cleared by ack", 16'(irq_pending), 16'd0);
        mwrite(3'b100, 1'b0);
        rs_hi_in = 1'b1; tick(); rs_hi_in = 1'b0; tick();
        strobe();
        check("R3 masked", 16'(irq_pending), 16'd0);
        mwrite(3'b000, 1'b0); strobe();
        check_sel("R3 held while masked", 3'd4);
        do_ack(); en();
        rs_hi_in = 1'b1; tick(); rs_hi_in = 1'b0; tick();
        mwrite(3'b000, 1'b1); strobe();
        check("R3 clear command", 16'(irq_pending), 16'd0);

        // R9: new edge together with acknowledge
        rs_hi_in = 1'b1; tick(); rs_hi_in = 1'b0; tick();
        strobe();
        check_sel("R9 setup", 3'd4);
        ack = 1'b1; rs_hi_in = 1'b1; tick(); ack = 1'b0; rs_hi_in = 1'b0;
        check("R9 ack", 16'(irq_pending), 16'd0);
        en(); strobe();
        check_sel("R9 edge kept", 3'd4);
        do_ack();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule